// File: doc/BRIEF.md
# Multicycle Instruction Sequencer

This block is the control unit of a small 16-bit processor. It holds the program counter, the instruction register and the two registers that stage memory traffic: one for the address and one for the data. A phase machine moves each instruction through fetch, decode, address evaluation, operand fetch, execute and result store. It skips any phase the instruction does not need, so a load takes a different number of cycles from an operate or branch instruction.

Memory is word-addressed and uses a request/ready handshake. The sequencer holds its request until ready and waits in its phase until then. Operate instructions are computed by an external unit. That unit looks at the instruction word presented by the sequencer and returns a result. The sequencer writes the result into the register file through a write-enable, an index and data. Two memory-facing instructions are supported: a PC-relative load and a flag-tested conditional branch. Opcodes other than these two and the three operate opcodes do nothing and go back to fetch.

Top module: `instr_sequencer`

## Requirements
- R1: While reset is low and in the first cycle after it, pc_out is 0x0000, cc_out is 3'b010 (zero flag), mem_req is 0 and rf_we is 0. The first memory request after reset is for address 0x0000.
- R2: Each fetch places the current PC on mem_addr and raises pc_out by one in the same step. While the fetch request is pending, pc_out equals mem_addr + 1.
- R3: Once raised, mem_req stays high and mem_addr stays stable until a cycle in which mem_ready is high. mem_rdata is taken in that cycle.
- R4: Opcode 4'b0010 in bits [15:12] is a load. It reads memory at (incremented PC + sign-extended bits [8:0]) and writes that word to the register whose index is bits [11:9]. rf_we is high for exactly one cycle.
- R5: Every register write updates cc_out from the written word: bit 2 (N) when bit 15 is set, bit 1 (Z) when the word is zero, bit 0 (P) otherwise. Exactly one flag bit is ever set.
- R6: Opcode 4'b0000 is a branch. Bits [11:9] are a mask over N (bit 11), Z (bit 10) and P (bit 9). If any flag selected by the mask is set, the next fetch address is the incremented PC + sign-extended bits [8:0]. Otherwise it is the incremented PC.
- R7: A branch with mask 3'b000 never changes the fetch sequence. A branch with mask 3'b111 always branches.
- R8: Opcodes 4'b0001, 4'b0101 and 4'b1001 are operate instructions. During them exec_en is high for one cycle with ir_out holding the instruction and no memory request. alu_result, sampled in that cycle, is written to register bits [11:9] in the following cycle.
- R9: Any other opcode writes no register, leaves the flags alone, and is followed directly by the next sequential fetch.
- R10: With a ready memory, successive fetch requests start 4 cycles apart for a no-op, 5 for a branch, 6 for an operate instruction and 7 for a load. Within a load, the operand request starts 4 cycles after the fetch request. Every wait cycle adds one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req | output | 1 | Memory read request, held until ready |
| mem_addr | output | 16 | Word address of the request |
| mem_rdata | input | 16 | Word returned by memory, valid with ready |
| mem_ready | input | 1 | Memory completes the request this cycle |
| ir_out | output | 16 | Current instruction word |
| exec_en | output | 1 | Operate instruction is executing this cycle |
| alu_result | input | 16 | Result from the operate unit |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 3 | Register index to write |
| rf_wdata | output | 16 | Word to write |
| pc_out | output | 16 | Program counter |
| cc_out | output | 3 | Flags {N, Z, P} |

## Verification
Two functions can land in the same cycle: the register write that ends one instruction and the flag update that the next branch depends on. A branch decides its target only a few cycles after the write, from the flags produced by that write. The bench provokes this by loading a negative word and following it at once with a branch that tests only N. It judges the result by the address of the next fetch request, and runs the sign-opposite pair the same way. Fetch-address capture and the PC increment also share one cycle. This is judged by comparing pc_out with mem_addr while the request is still held, both with a ready memory and with inserted wait states.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int WORD_W = 16;
  localparam int RIDX_W = 3;
  localparam int OPC_W  = 4;
  localparam int OFF_W  = 9;

  localparam logic [OPC_W-1:0] OPC_BRANCH = 4'b0000;
  localparam logic [OPC_W-1:0] OPC_LOAD   = 4'b0010;
  localparam logic [OPC_W-1:0] OPC_ADD    = 4'b0001;
  localparam logic [OPC_W-1:0] OPC_AND    = 4'b0101;
  localparam logic [OPC_W-1:0] OPC_NOT    = 4'b1001;

  typedef enum logic [2:0] {
    PH_FADDR, PH_FMEM, PH_FIR, PH_DECODE,
    PH_EVADDR, PH_OPND, PH_EXEC, PH_STORE
  } phase_t;

  typedef enum logic [1:0] {
    CLS_NONE, CLS_LOAD, CLS_BRANCH, CLS_OPER
  } iclass_t;

  function automatic iclass_t classify(input logic [OPC_W-1:0] opc);
    case (opc)
      OPC_LOAD:                   return CLS_LOAD;
      OPC_BRANCH:                 return CLS_BRANCH;
      OPC_ADD, OPC_AND, OPC_NOT:  return CLS_OPER;
      default:                    return CLS_NONE;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] pc_rel(input logic [WORD_W-1:0] pc,
                                               input logic [OFF_W-1:0] off);
    return pc + {{(WORD_W-OFF_W){off[OFF_W-1]}}, off};
  endfunction

  function automatic logic [2:0] flags_of(input logic [WORD_W-1:0] w);
    logic neg, zer;
    neg = w[WORD_W-1];
    zer = (w == '0);
    return {neg, zer, ~neg & ~zer};
  endfunction
endpackage

// File: rtl/seq_decoder.sv
module seq_decoder
  import seq_pkg::*;
(
  input  logic [OPC_W-1:0]  opc,
  input  logic [2:0]        fld,
  input  logic [2:0]        cc,
  output iclass_t           cls,
  output logic [RIDX_W-1:0] dst,
  output logic              hit
);
  logic [2:0] sel;

  assign cls = classify(opc);
  assign dst = fld;

  for (genvar g = 0; g < 3; g++) begin : g_mask
    assign sel[g] = fld[g] & cc[g];
  end

  assign hit = |sel;
endmodule

// File: rtl/seq_phase_fsm.sv
module seq_phase_fsm
  import seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  iclass_t cls,
  input  logic    mem_ready,
  output logic    fetch_issue,
  output logic    mem_req,
  output logic    mdr_load,
  output logic    ir_load,
  output logic    ea_load,
  output logic    exec_strobe,
  output logic    store_strobe
);
  phase_t ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    case (ph_q)
      PH_FADDR:  ph_d = PH_FMEM;
      PH_FMEM:   if (mem_ready) ph_d = PH_FIR;
      PH_FIR:    ph_d = PH_DECODE;
      PH_DECODE: begin
        case (cls)
          CLS_LOAD:   ph_d = PH_EVADDR;
          CLS_BRANCH: ph_d = PH_EXEC;
          CLS_OPER:   ph_d = PH_EXEC;
          default:    ph_d = PH_FADDR;
        endcase
      end
      PH_EVADDR: ph_d = PH_OPND;
      PH_OPND:   if (mem_ready) ph_d = PH_STORE;
      PH_EXEC:   ph_d = (cls == CLS_OPER) ? PH_STORE : PH_FADDR;
      PH_STORE:  ph_d = PH_FADDR;
      default:   ph_d = PH_FADDR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ph_q <= PH_FADDR;
    else        ph_q <= ph_d;
  end

  assign fetch_issue  = (ph_q == PH_FADDR);
  assign mem_req      = (ph_q == PH_FMEM) || (ph_q == PH_OPND);
  assign mdr_load     = mem_req && mem_ready;
  assign ir_load      = (ph_q == PH_FIR);
  assign ea_load      = (ph_q == PH_EVADDR);
  assign exec_strobe  = (ph_q == PH_EXEC);
  assign store_strobe = (ph_q == PH_STORE);
endmodule

// File: rtl/seq_arch_regs.sv
module seq_arch_regs
  import seq_pkg::*;
#(
  parameter logic [WORD_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  iclass_t           cls,
  input  logic              fetch_issue,
  input  logic              mdr_load,
  input  logic              ir_load,
  input  logic              ea_load,
  input  logic              exec_strobe,
  input  logic              store_strobe,
  input  logic              br_taken,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic [WORD_W-1:0] alu_result,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] pc_q,
  output logic [WORD_W-1:0] mar_q,
  output logic [WORD_W-1:0] mdr_q,
  output logic [WORD_W-1:0] ir_q,
  output logic [WORD_W-1:0] res_q,
  output logic [2:0]        cc_q
);
  logic [WORD_W-1:0] target;
  assign target = pc_rel(pc_q, ir_q[OFF_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= RESET_PC;
      mar_q <= '0;
      mdr_q <= '0;
      ir_q  <= '0;
      res_q <= '0;
      cc_q  <= 3'b010;
    end else begin
      if (fetch_issue) begin
        mar_q <= pc_q;
        pc_q  <= pc_q + 1'b1;
      end
      if (exec_strobe && cls == CLS_BRANCH && br_taken) pc_q <= target;
      if (ea_load)  mar_q <= target;
      if (mdr_load) mdr_q <= mem_rdata;
      if (ir_load)  ir_q  <= mdr_q;
      if (exec_strobe && cls == CLS_OPER) res_q <= alu_result;
      if (store_strobe) cc_q <= flags_of(wdata);
    end
  end
endmodule

// File: rtl/instr_sequencer.sv
module instr_sequencer
  import seq_pkg::*;
#(
  parameter logic [WORD_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_req,
  output logic [WORD_W-1:0] mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic [WORD_W-1:0] ir_out,
  output logic              exec_en,
  input  logic [WORD_W-1:0] alu_result,
  output logic              rf_we,
  output logic [RIDX_W-1:0] rf_waddr,
  output logic [WORD_W-1:0] rf_wdata,
  output logic [WORD_W-1:0] pc_out,
  output logic [2:0]        cc_out
);
  iclass_t           cls;
  logic              fetch_issue, mdr_load, ir_load, ea_load;
  logic              exec_strobe, store_strobe, br_taken, br_eval;
  logic [2:0]        br_mask;
  logic [WORD_W-1:0] pc_q, mar_q, mdr_q, ir_q, res_q, wdata;
  logic [2:0]        cc_q;
  logic [RIDX_W-1:0] dst;

  seq_decoder u_dec (
    .opc (ir_q[WORD_W-1 -: OPC_W]),
    .fld (ir_q[11:9]),
    .cc  (cc_q),
    .cls (cls),
    .dst (dst),
    .hit (br_taken)
  );

  seq_phase_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .cls          (cls),
    .mem_ready    (mem_ready),
    .fetch_issue  (fetch_issue),
    .mem_req      (mem_req),
    .mdr_load     (mdr_load),
    .ir_load      (ir_load),
    .ea_load      (ea_load),
    .exec_strobe  (exec_strobe),
    .store_strobe (store_strobe)
  );

  assign wdata = (cls == CLS_LOAD) ? mdr_q : res_q;

  seq_arch_regs #(.RESET_PC(RESET_PC)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .cls          (cls),
    .fetch_issue  (fetch_issue),
    .mdr_load     (mdr_load),
    .ir_load      (ir_load),
    .ea_load      (ea_load),
    .exec_strobe  (exec_strobe),
    .store_strobe (store_strobe),
    .br_taken     (br_taken),
    .mem_rdata    (mem_rdata),
    .alu_result   (alu_result),
    .wdata        (wdata),
    .pc_q         (pc_q),
    .mar_q        (mar_q),
    .mdr_q        (mdr_q),
    .ir_q         (ir_q),
    .res_q        (res_q),
    .cc_q         (cc_q)
  );

  assign br_eval  = exec_strobe && (cls == CLS_BRANCH);
  assign br_mask  = ir_q[11:9];

  assign mem_addr = mar_q;
  assign ir_out   = ir_q;
  assign exec_en  = exec_strobe && (cls == CLS_OPER);
  assign rf_we    = store_strobe;
  assign rf_waddr = dst;
  assign rf_wdata = wdata;
  assign pc_out   = pc_q;
  assign cc_out   = cc_q;
endmodule

// File: rtl/seq_checker.sv
module seq_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_ready,
  input logic [15:0] mem_addr,
  input logic [15:0] pc_out,
  input logic [2:0]  cc_out,
  input logic        rf_we,
  input logic        exec_en,
  input logic        fetch_issue,
  input logic        br_eval,
  input logic [2:0]  br_mask,
  input logic        br_taken
);
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr));

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_issue |=> pc_out == $past(pc_out) + 16'd1);

  assert_one_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cc_out) == 1);

  assert_write_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> !rf_we);

  assert_exec_no_mem_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en |-> !mem_req);

  assert_exec_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en |=> !exec_en && rf_we);

  assert_mask_none_R7: assert property (@(posedge clk) disable iff (!rst_n)
    br_eval && br_mask == 3'b000 |-> !br_taken);

  assert_mask_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    br_eval && br_mask == 3'b111 |-> br_taken);
endmodule

bind instr_sequencer seq_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mem_req     (mem_req),
  .mem_ready   (mem_ready),
  .mem_addr    (mem_addr),
  .pc_out      (pc_out),
  .cc_out      (cc_out),
  .rf_we       (rf_we),
  .exec_en     (exec_en),
  .fetch_issue (fetch_issue),
  .br_eval     (br_eval),
  .br_mask     (br_mask),
  .br_taken    (br_taken)
);

// File: tb/instr_sequencer_bench.sv
module instr_sequencer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_req, mem_ready, exec_en, rf_we;
  logic [15:0] mem_addr, mem_rdata, ir_out, alu_result, rf_wdata, pc_out;
  logic [2:0]  rf_waddr, cc_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  instr_sequencer u_instr_sequencer (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .ir_out(ir_out),
    .exec_en(exec_en), .alu_result(alu_result), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .pc_out(pc_out), .cc_out(cc_out)
  );

  // memory model with a programmable number of wait cycles
  logic [15:0] mem [0:255];
  int          lat = 0;
  int          wcnt;
  assign mem_ready = mem_req && (wcnt >= lat);
  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    if (!rst_n || !mem_req || mem_ready) wcnt <= 0;
    else                                 wcnt <= wcnt + 1;
  end

  // register file and operate unit model
  logic [15:0] breg [0:7];
  always @(posedge clk) begin
    if (!rst_n) for (int i = 0; i < 8; i++) breg[i] <= 16'h0;
    else if (rf_we) breg[rf_waddr] <= rf_wdata;
  end

  logic [15:0] op_a, op_b;
  always_comb begin
    op_a = breg[ir_out[8:6]];
    op_b = ir_out[5] ? {{11{ir_out[4]}}, ir_out[4:0]} : breg[ir_out[2:0]];
    case (ir_out[15:12])
      4'b0001: alu_result = op_a + op_b;
      4'b0101: alu_result = op_a & op_b;
      4'b1001: alu_result = ~op_a;
      default: alu_result = 16'h0;
    endcase
  end

  // request / event logger, sampled on falling edges
  int          cyc, nreq, nwr, nexec;
  int          req_t [0:15];
  logic [15:0] req_a [0:15];
  logic [15:0] req_pc [0:15];
  logic [15:0] first_exec_ir;
  logic        prev_req;

  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0; nreq = 0; nwr = 0; nexec = 0; prev_req = 1'b0;
    end else begin
      if (mem_req && !prev_req && nreq < 16) begin
        req_t[nreq] = cyc; req_a[nreq] = mem_addr; req_pc[nreq] = pc_out;
        nreq++;
      end
      if (rf_we) nwr++;
      if (exec_en) begin
        if (nexec == 0) first_exec_ir = ir_out;
        nexec++;
      end
      prev_req = mem_req;
      cyc++;
    end
  end

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic start(input int latency);
    rst_n = 1'b0;
    lat = latency;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    clear_mem();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 pc in reset", pc_out, 16'h0);
    chk("R1 flags in reset", cc_out, 3'b010);
    chk("R1 req/we in reset", {mem_req, rf_we}, 2'b00);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pc first cycle", pc_out, 16'h0);
    chk("R1 no req first cycle", mem_req, 1'b0);
    @(negedge clk);
    chk("R1 first fetch address", {mem_req, mem_addr}, {1'b1, 16'h0});
    chk("R2 pc incremented with fetch", pc_out, 16'h1);
  endtask

  task automatic t_noop();
    clear_mem();
    mem[0] = 16'hD000;
    start(0); run(12);
    chk("R9 next fetch sequential", req_a[1], 16'h1);
    chk("R10 no-op spacing", req_t[1] - req_t[0], 4);
    chk("R9 no register write", nwr, 0);
    chk("R9 flags untouched", cc_out, 3'b010);
  endtask

  task automatic t_load_fwd();
    clear_mem();
    mem[0] = 16'h2605;  // load r3, +5 -> address 6
    mem[6] = 16'h8001;
    start(0); run(14);
    chk("R4 operand address", req_a[1], 16'h6);
    chk("R10 load fetch-to-operand", req_t[1] - req_t[0], 4);
    chk("R10 load operand-to-fetch", req_t[2] - req_t[1], 3);
    chk("R4 loaded register", breg[3], 16'h8001);
    chk("R4 single write", nwr, 1);
    chk("R5 negative flag", cc_out, 3'b100);
  endtask

  task automatic t_load_wait();
    clear_mem();
    mem[0] = 16'h23FF;  // load r1, -1 -> address 0
    start(3); run(24);
    chk("R3 R4 operand address back", req_a[1], 16'h0);
    chk("R2 pc during held fetch", req_pc[0], 16'h1);
    chk("R3 R10 spacing with waits", req_t[1] - req_t[0], 7);
    chk("R3 R10 operand spacing with waits", req_t[2] - req_t[1], 6);
    chk("R4 loaded self word", breg[1], 16'h23FF);
    chk("R5 positive flag", cc_out, 3'b001);
  endtask

  task automatic t_operate();
    clear_mem();
    mem[0] = 16'h54A0;  // and r2, r2, #0
    mem[1] = 16'h14BD;  // add r2, r2, #-3
    mem[2] = 16'h1A82;  // add r5, r2, r2
    mem[3] = 16'h9D7F;  // not r6, r5
    start(0); run(30);
    chk("R8 no operand requests", {req_a[1], req_a[2], req_a[3]}, {16'h1, 16'h2, 16'h3});
    chk("R10 operate spacing", req_t[1] - req_t[0], 6);
    chk("R8 instruction during exec", first_exec_ir, 16'h54A0);
    chk("R8 immediate add", breg[2], 16'hFFFD);
    chk("R8 register add", breg[5], 16'hFFFA);
    chk("R8 not", breg[6], 16'h0005);
    chk("R5 flag after not", cc_out, 3'b001);
  endtask

  task automatic t_branch_p();
    clear_mem();
    mem[0] = 16'h23FF;  // load sets P
    mem[1] = 16'h0203;  // branch P, +3 -> 5
    start(0); run(20);
    chk("R6 taken target", req_a[3], 16'h5);
    chk("R10 branch spacing", req_t[3] - req_t[2], 5);
  endtask

  task automatic t_branch_miss();
    clear_mem();
    mem[0] = 16'h23FF;  // load sets P
    mem[1] = 16'h0803;  // branch N only
    start(0); run(20);
    chk("R6 not taken", req_a[3], 16'h2);
  endtask

  task automatic t_mask_edges();
    clear_mem();
    mem[0] = 16'h0003;  // mask 000
    start(0); run(10);
    chk("R7 mask none falls through", req_a[1], 16'h1);
    clear_mem();
    mem[0] = 16'h0E04;  // mask 111, +4
    start(0); run(10);
    chk("R7 mask all branches", req_a[1], 16'h5);
    clear_mem();
    mem[0] = 16'h05FF;  // mask Z, -1 -> 0
    start(0); run(10);
    chk("R6 R1 zero flag negative offset", req_a[1], 16'h0);
  endtask

  task automatic t_flag_then_branch();
    clear_mem();
    mem[0] = 16'h2804;  // load r4, +4 -> address 5
    mem[5] = 16'h8000;
    mem[1] = 16'h0802;  // branch N, +2 -> 4
    start(0); run(20);
    chk("R5 R6 branch sees fresh N", req_a[3], 16'h4);
  endtask

  initial begin
    clear_mem();
    t_reset();
    t_noop();
    t_load_fwd();
    t_load_wait();
    t_operate();
    t_branch_p();
    t_branch_miss();
    t_mask_edges();
    t_flag_then_branch();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule